// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write-Protect Register

This block is the target side of a two-wire serial EEPROM. It watches the clock line and the data line, recognises START and STOP, takes a control byte and a low address byte, and then either stores incoming data bytes or returns stored bytes in address order. The data line is open-drain. The block drives it through `sda_oe`, where a 1 pulls the line low, and it reads the resolved line on `sda_in`. The array depth is set by `ADDR_W`. The control byte always has room for five high address bits, and only those below `ADDR_W` are used. The default of 11 gives a 2 KiB array. An `ADDR_W` of 13 gives the full 8K map.

The all-ones address has two meanings. When that address comes straight from an address phase, the first data byte reaches an 8-bit protection register. When the address arrives there by incrementing during a sequential transfer, the byte reaches the array cell. The protection register holds three things:
- a write-enable latch, which gates array writes;
- a register-unlock latch;
- a pin-lock enable and a two-bit protected-region code.

The pin-lock enable and the region code change only after an unlock sequence. A transfer that changes the array or commits the register starts a fixed busy period at STOP. During that period no control byte is acknowledged.

Top module: `eep_slave_2w`

## Requirements
- R1: A control byte whose bits 7:6 are `10` is acknowledged on the ninth clock. Any other code is not acknowledged, and the slave then leaves the data line released until the next START.
- R2: Control byte bits 5:1 carry address bits 12:8, and only bits below `ADDR_W` are kept. The byte after a write control byte carries address bits 7:0. Each transferred data byte advances the address by one, and the address wraps from all-ones to zero.
- R3: The slave pulls the data line low on the ninth clock after every address byte and every write data byte, including data bytes that it then discards.
- R4: Read data leaves the slave MSB first. The master's ACK (line low) starts the byte at the next address. After the master's NACK, the slave releases the line.
- R5: When the first data byte after an address phase targets the all-ones address, it reads or writes the protection register. The register reads as {pin-lock enable, 0, 0, region[1:0], unlock latch, enable latch, 0}. A sequential transfer that steps into the all-ones address reaches the array byte instead.
- R6: Writing 0x02 to the register sets the enable latch. Writing 0x06 while the enable latch is set sets the unlock latch. While the unlock latch is set, a write with bit 2 clear loads bit 7 and bits 4:3, loads the enable latch from bit 1, and clears the unlock latch. Writes out of this order never change bit 7 or bits 4:3. A write with bits 2:1 both clear also clears the enable latch.
- R7: While the enable latch is clear, array writes are discarded.
- R8: Region code 00 protects nothing, 01 protects the top quarter of the array, 10 the top half, and 11 the whole array. Writes into a protected region are discarded.
- R9: While the `wp` pin is high and the pin-lock enable is set, every register write is discarded.
- R10: At STOP, a transfer that changed an array byte or committed the register starts a busy period of `BUSY_CYC` clocks, during which control bytes get no ACK. A transfer that changed nothing starts no busy period.
- R11: After reset the register reads 0x00, the data line is released and the slave is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Serial clock line level |
| sda_in | input | 1 | Resolved data line level |
| wp | input | 1 | Pin that locks the register while the pin-lock enable is set |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Two functions can meet in one cycle: the STOP that ends a write starts the busy timer, and the very next control byte needs an ACK decision. The bench issues a START and a control byte straight after such a STOP and expects no ACK. It then repeats the same sequence after a write that was discarded and expects an ACK. The second function pair is the all-ones address: a sequential write and read cross it, and the bench checks that the register value stays put while the array byte changes.

// File: rtl/eep_pkg.sv
// Package: shared state encoding and the region-protection decode for the
// two-wire EEPROM slave. Assumes the region code is two bits wide.
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_CTRL,    // shifting in the control byte
        ST_ADDR,    // shifting in the low address byte
        ST_WDATA,   // shifting in write data
        ST_ACK,     // slave holds ACK for one clock
        ST_RDATA,   // shifting out read data
        ST_RACK,    // sampling the master ACK/NACK
        ST_SKIP     // off the bus until START/STOP
    } bus_st_t;

    // True when an address whose two top bits are msb2 lies in the region
    // protected by region code rg.
    function automatic logic region_hit(input logic [1:0] rg, input logic [1:0] msb2);
        case (rg)
            2'b00:   region_hit = 1'b0;
            2'b01:   region_hit = (msb2 == 2'b11);
            2'b10:   region_hit = msb2[1];
            default: region_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eep_line_sense.sv
// Line sensing: registers both bus lines on clk and derives clock edges and
// START/STOP events. Assumes the lines are already synchronous and glitch
// free; one register stage is applied before edge detection.
module eep_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q1, scl_q2, sda_q1, sda_q2;

    // Purpose: two-deep history of each line, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q1 <= 1'b1;
            scl_q2 <= 1'b1;
            sda_q1 <= 1'b1;
            sda_q2 <= 1'b1;
        end else begin
            scl_q1 <= scl;
            scl_q2 <= scl_q1;
            sda_q1 <= sda;
            sda_q2 <= sda_q1;
        end
    end

    // Purpose: edge and bus-condition decode from the history.
    always_comb begin
        sda_lvl  = sda_q1;
        scl_rise = scl_q1 & ~scl_q2;
        scl_fall = ~scl_q1 & scl_q2;
        start_c  = scl_q1 & scl_q2 & sda_q2 & ~sda_q1;
        stop_c   = scl_q1 & scl_q2 & ~sda_q2 & sda_q1;
    end
endmodule

// File: rtl/eep_guard.sv
// Protection register: enable latch, unlock latch, pin-lock enable and
// region code, with the two-step unlock sequence. Assumes wr_en is a
// single-cycle strobe carrying a complete received byte.
module eep_guard (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wp,
    input  logic       d_lock,
    input  logic [1:0] d_region,
    input  logic       d_unlock,
    input  logic       d_enable,
    output logic [7:0] rd_val,
    output logic       wel,
    output logic [1:0] region,
    output logic       commit
);
    logic lock_q, unlock_q, wel_q;
    logic [1:0] region_q;
    logic blocked;

    // Purpose: decide whether a write is blocked and whether it commits.
    always_comb begin
        blocked = wp & lock_q;
        commit  = wr_en & ~blocked & unlock_q & ~d_unlock;
        rd_val  = {lock_q, 2'b00, region_q, unlock_q, wel_q, 1'b0};
        wel     = wel_q;
        region  = region_q;
    end

    // Purpose: latch sequencing and committed-field update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            region_q <= 2'b00;
            unlock_q <= 1'b0;
            wel_q    <= 1'b0;
        end else if (wr_en && !blocked) begin
            if (commit) begin
                lock_q   <= d_lock;
                region_q <= d_region;
                unlock_q <= 1'b0;
                wel_q    <= d_enable;
            end else if (d_unlock && d_enable) begin
                if (wel_q) unlock_q <= 1'b1;
            end else if (d_enable) begin
                wel_q <= 1'b1;
            end else if (!d_unlock) begin
                wel_q <= 1'b0;
            end
        end
    end

    // R6: the unlock latch rises only while the enable latch is set
    assert_unlock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_q) |-> $past(wel_q));

    // R6: the protected fields change only while the unlock latch was set
    assert_commit_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ({lock_q, region_q} != $past({lock_q, region_q})) |-> $past(unlock_q));

    // R9: pin lock freezes the whole register
    assert_pin_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp && lock_q) |=> $stable({lock_q, region_q, unlock_q, wel_q}));
endmodule

// File: rtl/eep_busy_timer.sv
// Busy timer: a kick loads BUSY_CYC and busy stays high until the count runs
// out. Assumes BUSY_CYC >= 1.
module eep_busy_timer #(
    parameter int BUSY_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    logic [CW-1:0] left_q;

    // Purpose: load on kick, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           left_q <= '0;
        else if (kick)        left_q <= CW'(BUSY_CYC);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/eep_slave_2w.sv
// Two-wire EEPROM slave top: byte engine, address pointer, array and the
// register/array steering. Assumes ADDR_W is 9..13 and that scl/sda_in
// change slowly relative to clk (several clk cycles per bus phase).
module eep_slave_2w #(
    parameter int ADDR_W   = 11,
    parameter int BUSY_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    input  logic wp,
    output logic sda_oe
);
    import eep_pkg::*;

    localparam int HI_W  = ADDR_W - 8;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP_A = '1;

    logic sda_lvl, scl_rise, scl_fall, start_c, stop_c;
    logic busy, wel, commit, reg_we, mem_we, byte_end, m_ack;
    logic [1:0] region;
    logic [7:0] reg_val, rd_byte, shreg;
    logic [3:0] cnt;
    logic [ADDR_W-1:0] ptr;
    logic reg_sel, nv_pend;
    bus_st_t st, ret_st;
    logic [7:0] mem [DEPTH];

    eep_line_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    eep_guard u_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wp(wp),
        .d_lock(shreg[7]), .d_region(shreg[4:3]), .d_unlock(shreg[2]),
        .d_enable(shreg[1]), .rd_val(reg_val), .wel(wel), .region(region),
        .commit(commit)
    );

    eep_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .kick(stop_c & nv_pend), .busy(busy)
    );

    // Purpose: write strobes for the register and the array, read steering.
    always_comb begin
        byte_end = scl_fall && (cnt == 4'd8);
        reg_we   = (st == ST_WDATA) && byte_end && reg_sel;
        mem_we   = (st == ST_WDATA) && byte_end && !reg_sel && wel
                   && !region_hit(region, ptr[ADDR_W-1 -: 2]);
        rd_byte  = reg_sel ? reg_val : mem[ptr];
    end

    // Purpose: array storage, written one byte per accepted data byte.
    always_ff @(posedge clk) begin
        if (mem_we) mem[ptr] <= shreg;
    end

    // Purpose: bus byte engine, pointer and ACK drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  ret_st <= ST_IDLE;
            cnt <= '0;  shreg <= '0;  ptr <= '0;
            reg_sel <= 1'b0;  nv_pend <= 1'b0;  sda_oe <= 1'b0;  m_ack <= 1'b0;
        end else if (stop_c) begin
            st <= ST_IDLE;  sda_oe <= 1'b0;  reg_sel <= 1'b0;  nv_pend <= 1'b0;
        end else if (start_c) begin
            st <= ST_CTRL;  cnt <= '0;  sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_end) begin
                        cnt <= '0;
                        if (st == ST_CTRL) begin
                            if (shreg[7:6] == 2'b10 && !busy) begin
                                sda_oe <= 1'b1;
                                st     <= ST_ACK;
                                ptr[ADDR_W-1:8] <= shreg[HI_W:1];
                                if (shreg[0]) begin
                                    ret_st  <= ST_RDATA;
                                    reg_sel <= reg_sel && ({shreg[HI_W:1], ptr[7:0]} == TOP_A);
                                end else begin
                                    ret_st  <= ST_ADDR;
                                end
                            end else begin
                                st <= ST_SKIP;
                            end
                        end else if (st == ST_ADDR) begin
                            ptr[7:0] <= shreg;
                            reg_sel  <= ({ptr[ADDR_W-1:8], shreg} == TOP_A);
                            sda_oe   <= 1'b1;
                            st       <= ST_ACK;
                            ret_st   <= ST_WDATA;
                        end else begin
                            ptr     <= ptr + ADDR_W'(1);
                            reg_sel <= 1'b0;
                            if (mem_we || commit) nv_pend <= 1'b1;
                            sda_oe  <= 1'b1;
                            st      <= ST_ACK;
                            ret_st  <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (ret_st == ST_RDATA) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            cnt    <= 4'd1;
                        end else begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end
                        st <= ret_st;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe  <= 1'b0;
                            st      <= ST_RACK;
                            ptr     <= ptr + ADDR_W'(1);
                            reg_sel <= 1'b0;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) m_ack <= ~sda_lvl;
                    if (scl_fall) begin
                        if (m_ack) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            cnt    <= 4'd1;
                            st     <= ST_RDATA;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: the line drive only changes after a clock fall or a bus condition
    assert_drive_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));

    // R10: a control byte that ends while busy is never acknowledged
    assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTRL && byte_end && busy && !stop_c && !start_c) |=> (!sda_oe && st == ST_SKIP));

    // R1: a wrong device code leaves the line released
    assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe);
endmodule

// File: tb/sim_eep_slave_2w.sv
module sim_eep_slave_2w;
    localparam int BUSY = 200;
    localparam logic [12:0] TOPA = 13'h7FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic bus;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;
    assign bus = m_sda & ~sda_oe;

    eep_slave_2w #(.ADDR_W(11), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(bus), .wp(wp), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic b_start();
        m_sda = 1'b1; half(); scl = 1'b1; half(); m_sda = 1'b0; half(); scl = 1'b0; half();
    endtask

    task automatic b_stop();
        m_sda = 1'b0; half(); scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask

    task automatic tx(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
        end
        m_sda = 1'b1; half(); scl = 1'b1; half(); ack = ~bus; scl = 1'b0; half();
    endtask

    task automatic rx(input logic mack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half(); scl = 1'b1; half(); d[i] = bus; scl = 1'b0;
        end
        half(); m_sda = ~mack; half(); scl = 1'b1; half(); scl = 1'b0; half(); m_sda = 1'b1;
    endtask

    function automatic logic [7:0] ctl(input logic [12:0] a, input logic rd);
        return {2'b10, a[12:8], rd};
    endfunction

    // write up to three bytes from address a; all_ack reports every ACK
    task automatic wr(input logic [12:0] a, input int n, input logic [7:0] b0, b1, b2,
                      input bit settle, output logic all_ack);
        logic k;
        logic [7:0] v [3];
        v[0] = b0; v[1] = b1; v[2] = b2;
        all_ack = 1'b1;
        b_start();
        tx(ctl(a, 1'b0), k); all_ack &= k;
        tx(a[7:0], k);       all_ack &= k;
        for (int i = 0; i < n; i++) begin
            tx(v[i], k); all_ack &= k;
        end
        b_stop();
        if (settle) repeat (BUSY + 16) @(negedge clk);
    endtask

    task automatic rd(input logic [12:0] a, input int n, output logic [7:0] r0, r1, r2);
        logic k;
        logic [7:0] v [3];
        v[0] = 8'h00; v[1] = 8'h00; v[2] = 8'h00;
        b_start();
        tx(ctl(a, 1'b0), k);
        tx(a[7:0], k);
        b_start();
        tx(ctl(a, 1'b1), k);
        for (int i = 0; i < n; i++) rx(i < n - 1, v[i]);
        chk("R4 line released after NACK", {7'd0, sda_oe}, 8'h00);
        b_stop();
        r0 = v[0]; r1 = v[1]; r2 = v[2];
    endtask

    task automatic probe(output logic ack);
        b_start(); tx(ctl(13'h0, 1'b0), ack); b_stop();
    endtask

    task automatic reg_wr(input logic [7:0] v);
        logic k;
        wr(TOPA, 1, v, 8'h00, 8'h00, 1'b1, k);
    endtask

    task automatic reg_rd(input string tag, input logic [7:0] exp);
        logic [7:0] a, b, c;
        rd(TOPA, 1, a, b, c);
        chk(tag, a, exp);
    endtask

    task automatic t_reset();
        chk("R11 line released at reset", {7'd0, sda_oe}, 8'h00);
        reg_rd("R11 register zero after reset", 8'h00);
    endtask

    task automatic t_devcode();
        logic k;
        b_start(); tx(8'hC0, k); b_stop();
        chk("R1 wrong code not acked", {7'd0, k}, 8'h00);
        probe(k);
        chk("R1 right code acked", {7'd0, k}, 8'h01);
    endtask

    task automatic t_enable_and_busy();
        logic k;
        logic [7:0] a, b, c;
        reg_wr(8'h02);
        reg_rd("R6 enable latch set by 0x02", 8'h02);
        wr(13'h010, 1, 8'h11, 8'h00, 8'h00, 1'b0, k);
        probe(k);
        chk("R10 control byte refused right after array write", {7'd0, k}, 8'h00);
        repeat (BUSY + 16) @(negedge clk);
        probe(k);
        chk("R10 control byte accepted after busy period", {7'd0, k}, 8'h01);
        rd(13'h010, 1, a, b, c);
        chk("R2 random read returns stored byte", a, 8'h11);
        reg_wr(8'h00);
        reg_rd("R6 0x00 clears enable latch", 8'h00);
        wr(13'h010, 1, 8'h55, 8'h00, 8'h00, 1'b0, k);
        chk("R3 discarded data byte still acked", {7'd0, k}, 8'h01);
        probe(k);
        chk("R10 no busy after discarded write", {7'd0, k}, 8'h01);
        rd(13'h010, 1, a, b, c);
        chk("R7 write with enable clear discarded", a, 8'h11);
    endtask

    task automatic t_sequential();
        logic k;
        logic [7:0] a, b, c;
        reg_wr(8'h02);
        wr(13'h123, 3, 8'hA1, 8'hA2, 8'hA3, 1'b1, k);
        chk("R3 address and data bytes acked", {7'd0, k}, 8'h01);
        rd(13'h123, 3, a, b, c);
        chk("R4 sequential read byte 0", a, 8'hA1);
        chk("R4 sequential read byte 1", b, 8'hA2);
        chk("R2 sequential read byte 2", c, 8'hA3);
    endtask

    task automatic t_top_cross();
        logic k;
        logic [7:0] a, b, c;
        wr(13'h7FE, 3, 8'h3C, 8'h5A, 8'h77, 1'b1, k);
        reg_rd("R5 sequential write skips register", 8'h02);
        rd(13'h7FE, 3, a, b, c);
        chk("R5 below top", a, 8'h3C);
        chk("R5 crossing into top reaches array", b, 8'h5A);
        chk("R2 address wraps to zero", c, 8'h77);
    endtask

    task automatic t_order();
        reg_wr(8'h00);
        reg_wr(8'h06);
        reg_rd("R6 0x06 without enable latch ignored", 8'h00);
        reg_wr(8'h1A);
        reg_rd("R6 write without unlock keeps region", 8'h02);
    endtask

    task automatic t_region();
        logic k;
        logic [7:0] a, b, c;
        reg_wr(8'h06);
        reg_rd("R6 0x06 sets unlock latch", 8'h06);
        reg_wr(8'h0A);
        reg_rd("R6 commit loads region 01", 8'h0A);
        wr(13'h7FE, 1, 8'h99, 8'h00, 8'h00, 1'b0, k);
        probe(k);
        chk("R10 no busy after protected write", {7'd0, k}, 8'h01);
        wr(13'h5FF, 1, 8'h81, 8'h00, 8'h00, 1'b1, k);
        rd(13'h7FE, 1, a, b, c);
        chk("R8 top quarter protected with 01", a, 8'h3C);
        rd(13'h5FF, 1, a, b, c);
        chk("R8 below top quarter writable with 01", a, 8'h81);
        reg_wr(8'h06);
        reg_wr(8'h1A);
        reg_rd("R8 region 11 committed", 8'h1A);
        wr(13'h000, 1, 8'h44, 8'h00, 8'h00, 1'b1, k);
        rd(13'h000, 1, a, b, c);
        chk("R8 whole array protected with 11", a, 8'h77);
    endtask

    task automatic t_pin_lock();
        reg_wr(8'h06);
        reg_wr(8'h82);
        reg_rd("R6 commit loads pin-lock enable", 8'h82);
        wp = 1'b1;
        reg_wr(8'h00);
        reg_rd("R9 pin lock blocks clear", 8'h82);
        reg_wr(8'h06);
        reg_rd("R9 pin lock blocks unlock", 8'h82);
        wp = 1'b0;
        reg_wr(8'h00);
        reg_rd("R9 pin low allows write", 8'h80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_devcode();
        t_enable_and_busy();
        t_sequential();
        t_top_cross();
        t_order();
        t_region();
        t_pin_lock();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule